// File: doc/BRIEF.md
# Stop-Mode Wake and Interrupt Entry Controller

This controller sits on the CPU side of a small processor core. Software can park the core in a clock-stopped state by writing 1 to a stop control bit. Any hardware interrupt request clears that bit and wakes the core. An oscillator settling wait, modelled by a cycle counter, follows unless the slow auxiliary clock is selected.

After the wake, the controller runs the fixed bus sequence that enters an interrupt:
- reads an interrupt descriptor at address zero;
- saves the flag and program-counter state to the stack in two writes;
- clears selected flags;
- fetches a two-word handler address;
- loads the interrupt priority level;
- signals completion.

A software interrupt, given as a number, enters the same sequence directly. It skips the descriptor read and leaves the priority level alone.

The stack pointer and priority level are registers held inside this block. The flags and the program counter come from the core. Each bus state takes one clock, and read data is taken in the same cycle as the read strobe.

Top module: `stop_wake_irq_seq`

## Requirements
- R1: A `stop_set` pulse while idle, with no hardware request in the same cycle, raises `stop_q` on the next cycle. While `stop_q` is high, `bus_rd` and `bus_wr` stay low.
- R2: A hardware request while stopped lowers `stop_q` on the next cycle and sets `bclk_div8`. With the main clock selected, the bus stays quiet for exactly START_CYCLES cycles. The descriptor read then follows.
- R3: With `sub_clk_sel` high, a wake goes straight to the descriptor read with no settling wait, and `bclk_div8` keeps its value.
- R4: A hardware entry starts with one read at address 0. Descriptor bits [5:0] give the interrupt number and bits [10:8] give the level. In the following cycle, `irq_clr` pulses for one cycle with `irq_clr_num` equal to that number.
- R5: The flags saved are the `flg_in` value of the cycle before the sequence began. In the first write cycle, `flg_we` pulses with `flg_out` equal to that value, except that bit 6 (interrupt enable), bit 1 (debug) and bit 7 (stack select) are 0.
- R6: A `swi_req` pulse starts the sequence at the first write with number `swi_num`. For numbers 32 to 63, bit 7 of `flg_out` keeps its saved value; for numbers below 32 it is cleared. A software entry leaves `ipl` unchanged. A hardware entry always clears bit 7.
- R7: Two consecutive writes follow the descriptor read. The first goes to SP-2 with data {PC[19:16], saved flags[11:0]}. The second goes to SP-4 with data PC[15:0], using the PC of the cycle before the sequence began.
- R8: After the writes come reads at vec = VEC_BASE + 4*number and then at vec+2. `pc_new` becomes {second word[3:0], first word}.
- R9: In the cycle after the vec+2 read, `done` is high for exactly one cycle. In that cycle `pc_new` is valid, `sp` equals its old value minus 4, and `ipl` holds the descriptor level (hardware entries only).
- R10: A hardware request in the same idle cycle as `stop_set` or `swi_req` wins. `stop_q` stays low, and the descriptor read comes on the next cycle.
- R11: While a sequence runs, `stop_set` and `swi_req` have no effect. After `done`, the block returns to idle with `stop_q` low and the bus quiet.
- R12: `bclk_div8` is 1 after reset, and a `div_full` pulse clears it on the next cycle.
- R13: A hardware entry from the running state spans six cycles: descriptor read, two writes, two vector reads, and the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stop_set | input | 1 | Software write of 1 to the stop bit |
| div_full | input | 1 | Software selects undivided bus clock |
| sub_clk_sel | input | 1 | Auxiliary clock is the bus clock source |
| irq_req | input | 1 | Hardware interrupt request |
| swi_req | input | 1 | Software interrupt pulse |
| swi_num | input | 6 | Software interrupt number |
| flg_in | input | 12 | Current flag register |
| pc_in | input | 20 | Current program counter |
| bus_addr | output | 20 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rdata | input | 16 | Read data, same cycle |
| bus_wdata | output | 16 | Write data |
| stop_q | output | 1 | Stop bit |
| bclk_div8 | output | 1 | Bus clock divided by eight |
| irq_clr | output | 1 | Clear pulse for the accepted request |
| irq_clr_num | output | 6 | Number of the request to clear |
| flg_we | output | 1 | Flag register update strobe |
| flg_out | output | 12 | Flag value with entry bits cleared |
| sp | output | 16 | Stack pointer |
| ipl | output | 3 | Interrupt priority level |
| pc_new | output | 20 | Handler start address |
| done | output | 1 | Entry complete pulse |

## Verification
Two of the block's own functions can meet in a single idle cycle. In one case a hardware request lands together with a write of the stop bit. In the other it lands together with a software interrupt. The bench raises both inputs in the same cycle. It then expects `stop_q` to stay low, the descriptor read on the very next cycle, and no trace of the software number in the cleared-flag result.

A second overlap is `div_full` against a wake. It is judged by the `bclk_div8` value seen after each wake. The reference model predicts every strobe, address and data value cycle by cycle from the requirements and compares them on each clock.

// File: rtl/stop_wake_irq_seq.sv
module stop_wake_irq_seq #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int NW = 6,
  parameter int LW = 3,
  parameter int LVL_LSB = 8,
  parameter int START_CYCLES = 8,
  parameter logic [19:0] VEC_BASE = 20'hF0000,
  parameter logic [15:0] SP_RESET = 16'h0800,
  parameter int I_BIT = 6,
  parameter int D_BIT = 1,
  parameter int U_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop_set,
  input  logic          div_full,
  input  logic          sub_clk_sel,
  input  logic          irq_req,
  input  logic          swi_req,
  input  logic [5:0]    swi_num,
  input  logic [11:0]   flg_in,
  input  logic [19:0]   pc_in,
  output logic [19:0]   bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  input  logic [15:0]   bus_rdata,
  output logic [15:0]   bus_wdata,
  output logic          stop_q,
  output logic          bclk_div8,
  output logic          irq_clr,
  output logic [5:0]    irq_clr_num,
  output logic          flg_we,
  output logic [11:0]   flg_out,
  output logic [15:0]   sp,
  output logic [2:0]    ipl,
  output logic [19:0]   pc_new,
  output logic          done
);
  localparam int HW = AW - DW;
  localparam int FW = DW - HW;
  localparam int CW = $clog2(START_CYCLES + 1);

  typedef enum logic [3:0] {
    S_RUN, S_STOP, S_OSC, S_INFO, S_WFLG, S_WPC, S_VLO, S_VHI, S_DONE
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [FW-1:0] tmp;
  logic [AW-1:0] pc_q;
  logic [NW-1:0] num_q;
  logic [LW-1:0] lvl_q;
  logic          hw_q;
  logic [DW-1:0] vlo;
  logic          tracking;
  logic          keep_u;
  logic [AW-1:0] vec;
  logic [AW-1:0] stk;

  assign tracking = (st == S_RUN) || (st == S_STOP) || (st == S_OSC);
  assign keep_u   = !hw_q && (num_q >= NW'(32));
  assign vec      = VEC_BASE + {{(AW-NW-2){1'b0}}, num_q, 2'b00};
  assign stk      = {{HW{1'b0}}, sp};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_RUN;
      cnt       <= '0;
      tmp       <= '0;
      pc_q      <= '0;
      num_q     <= '0;
      lvl_q     <= '0;
      hw_q      <= 1'b0;
      vlo       <= '0;
      sp        <= SP_RESET;
      ipl       <= '0;
      pc_new    <= '0;
      bclk_div8 <= 1'b1;
    end else begin
      if (tracking) begin
        tmp  <= flg_in;
        pc_q <= pc_in;
      end
      if (div_full) bclk_div8 <= 1'b0;
      case (st)
        S_RUN: begin
          if (irq_req) begin
            st   <= S_INFO;
            hw_q <= 1'b1;
          end else if (swi_req) begin
            st    <= S_WFLG;
            hw_q  <= 1'b0;
            num_q <= swi_num;
          end else if (stop_set) begin
            st <= S_STOP;
          end
        end
        S_STOP: begin
          if (irq_req) begin
            hw_q <= 1'b1;
            cnt  <= '0;
            if (sub_clk_sel) begin
              st <= S_INFO;
            end else begin
              st        <= S_OSC;
              bclk_div8 <= 1'b1;
            end
          end
        end
        S_OSC: begin
          if (cnt == CW'(START_CYCLES - 1)) st <= S_INFO;
          else cnt <= cnt + 1'b1;
        end
        S_INFO: begin
          num_q <= bus_rdata[NW-1:0];
          lvl_q <= bus_rdata[LVL_LSB +: LW];
          st    <= S_WFLG;
        end
        S_WFLG: st <= S_WPC;
        S_WPC:  st <= S_VLO;
        S_VLO: begin
          vlo <= bus_rdata;
          st  <= S_VHI;
        end
        S_VHI: begin
          pc_new <= {bus_rdata[HW-1:0], vlo};
          sp     <= sp - DW'(4);
          if (hw_q) ipl <= lvl_q;
          st     <= S_DONE;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign stop_q      = (st == S_STOP);
  assign bus_rd      = (st == S_INFO) || (st == S_VLO) || (st == S_VHI);
  assign bus_wr      = (st == S_WFLG) || (st == S_WPC);
  assign done        = (st == S_DONE);
  assign irq_clr     = (st == S_WFLG) && hw_q;
  assign irq_clr_num = num_q;
  assign flg_we      = (st == S_WFLG);

  always_comb begin
    flg_out        = tmp;
    flg_out[I_BIT] = 1'b0;
    flg_out[D_BIT] = 1'b0;
    if (!keep_u) flg_out[U_BIT] = 1'b0;
  end

  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    case (st)
      S_WFLG: begin
        bus_addr  = stk - AW'(2);
        bus_wdata = {pc_q[AW-1:DW], tmp};
      end
      S_WPC: begin
        bus_addr  = stk - AW'(4);
        bus_wdata = pc_q[DW-1:0];
      end
      S_VLO:   bus_addr = vec;
      S_VHI:   bus_addr = vec + AW'(2);
      default: bus_addr = '0;
    endcase
  end

  assert_quiet_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> (!bus_rd && !bus_wr));
  assert_stop_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_q) |-> $past(stop_set));
  assert_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && irq_req) |=> !stop_q);
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  assert_stack_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && $past(bus_wr)) |-> (bus_addr == $past(bus_addr) - AW'(2)));
  assert_vec_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bus_rd) && $past(bus_rd, 2)));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_sp_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (sp == $past(sp) - DW'(4)));
endmodule

// File: tb/stop_wake_irq_seq_tb.sv
module stop_wake_irq_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int START = 8;

  logic clk = 0, rst_n = 0;
  logic stop_set = 0, div_full = 0, sub_clk_sel = 0, irq_req = 0, swi_req = 0;
  logic [5:0] swi_num = 0;
  logic [11:0] flg_in = 0;
  logic [19:0] pc_in = 0;
  logic [19:0] bus_addr;
  logic bus_rd, bus_wr;
  logic [15:0] bus_rdata, bus_wdata;
  logic stop_q, bclk_div8, irq_clr, flg_we, done;
  logic [5:0] irq_clr_num;
  logic [11:0] flg_out;
  logic [15:0] sp;
  logic [2:0] ipl;
  logic [19:0] pc_new;
  logic [15:0] info_word = 0;

  int checks = 0, errors = 0;
  bit finished = 0;
  int sp_m = 16'h0800;
  int ipl_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_rdata = (bus_addr == 20'h0) ? info_word : (bus_addr[15:0] ^ 16'hA5C3);

  stop_wake_irq_seq #(.START_CYCLES(START)) u_dut (
    .clk(clk), .rst_n(rst_n), .stop_set(stop_set), .div_full(div_full),
    .sub_clk_sel(sub_clk_sel), .irq_req(irq_req), .swi_req(swi_req),
    .swi_num(swi_num), .flg_in(flg_in), .pc_in(pc_in), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .stop_q(stop_q), .bclk_div8(bclk_div8),
    .irq_clr(irq_clr), .irq_clr_num(irq_clr_num), .flg_we(flg_we),
    .flg_out(flg_out), .sp(sp), .ipl(ipl), .pc_new(pc_new), .done(done));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet(input string req);
    chk(!bus_rd && !bus_wr && !done, req, {bus_rd, bus_wr, done}, 0);
  endtask

  function automatic [19:0] rd_model(input [19:0] a);
    return {4'h0, a[15:0] ^ 16'hA5C3};
  endfunction

  // Called while the first state of an entry is visible on the outputs.
  task automatic entry(input bit hw, input [5:0] num, input [2:0] lvl,
                       input [11:0] flg, input [19:0] pc, input bit noise);
    logic [11:0] f;
    logic [19:0] vec;
    logic [15:0] lo, hi;
    f = flg; f[6] = 0; f[1] = 0;
    if (hw || num < 32) f[7] = 0;
    vec = 20'hF0000 + 20'(num) * 4;
    lo = rd_model(vec); hi = rd_model(vec + 2);
    if (hw) begin
      chk(bus_rd && !bus_wr && bus_addr == 0, "R4 info read", {bus_rd, bus_addr}, {1'b1, 20'h0});
      tick();
    end
    flg_in = ~flg; pc_in = ~pc;
    if (noise) begin stop_set = 1; swi_req = 1; end
    chk(bus_wr && bus_addr == 20'(sp_m - 2), "R7 first write addr", bus_addr, 20'(sp_m - 2));
    chk(bus_wdata == {pc[19:16], flg}, "R7 first write data", bus_wdata, {pc[19:16], flg});
    chk(flg_we && flg_out == f, "R5/R6 cleared flags", {flg_we, flg_out}, {1'b1, f});
    chk(irq_clr == hw && (!hw || irq_clr_num == num), "R4 request clear", {irq_clr, irq_clr_num}, {hw, num});
    tick();
    chk(bus_wr && bus_addr == 20'(sp_m - 4) && bus_wdata == pc[15:0], "R7 second write",
        {bus_addr, bus_wdata}, {20'(sp_m - 4), pc[15:0]});
    chk(!irq_clr && !flg_we, "R4 clear pulse single", {irq_clr, flg_we}, 0);
    tick();
    chk(bus_rd && bus_addr == vec, "R8 vector low read", bus_addr, vec);
    tick();
    chk(bus_rd && bus_addr == vec + 2, "R8 vector high read", bus_addr, vec + 2);
    tick();
    sp_m = (sp_m - 4) & 16'hFFFF;
    if (hw) ipl_m = lvl;
    chk(done && !bus_rd && !bus_wr, "R9 done", done, 1);
    chk(pc_new == {hi[3:0], lo}, "R8 handler address", pc_new, {hi[3:0], lo});
    chk(sp == 16'(sp_m), "R9 stack pointer", sp, sp_m);
    chk(ipl == 3'(ipl_m), "R9/R6 priority level", ipl, ipl_m);
    if (noise) begin stop_set = 0; swi_req = 0; end
    tick();
    chk(!done, "R9 done single cycle", done, 0);
    quiet("R11 idle after done");
    chk(!stop_q, "R11 stop ignored while busy", stop_q, 0);
    flg_in = flg; pc_in = pc;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(!stop_q && sp == 16'h0800 && ipl == 0, "R1 reset state", {stop_q, sp, ipl}, {1'b0, 16'h0800, 3'h0});
    chk(bclk_div8, "R12 reset divider", bclk_div8, 1);
    quiet("R1 reset quiet");

    // R13: hardware entry from running state
    info_word = {5'h0, 3'd3, 2'b0, 6'd5};
    flg_in = 12'hFFF; pc_in = 20'h3_1234;
    irq_req = 1; tick(); irq_req = 0;
    entry(1, 6'd5, 3'd3, 12'hFFF, 20'h3_1234, 0);

    // R12: divider clear
    div_full = 1; tick(); div_full = 0;
    chk(!bclk_div8, "R12 divider cleared", bclk_div8, 0);

    // R1/R2: stop, then wake on main clock
    stop_set = 1; tick(); stop_set = 0;
    chk(stop_q, "R1 stop entered", stop_q, 1);
    for (int i = 0; i < 3; i++) begin quiet("R1 quiet in stop"); tick(); end
    chk(stop_q, "R1 stop held", stop_q, 1);
    info_word = {5'h0, 3'd6, 2'b0, 6'd40};
    flg_in = 12'h0C2; pc_in = 20'hA_BEEF;
    irq_req = 1; tick(); irq_req = 0;
    chk(!stop_q && bclk_div8, "R2 wake clears stop sets divider", {stop_q, bclk_div8}, 2'b01);
    for (int i = 0; i < START; i++) begin quiet("R2 settling quiet"); tick(); end
    entry(1, 6'd40, 3'd6, 12'h0C2, 20'hA_BEEF, 0);

    // R3: sub-clock wake
    div_full = 1; tick(); div_full = 0;
    sub_clk_sel = 1;
    stop_set = 1; tick(); stop_set = 0;
    chk(stop_q, "R3 stop entered", stop_q, 1);
    info_word = {5'h0, 3'd1, 2'b0, 6'd63};
    flg_in = 12'h8A5; pc_in = 20'h0_0100;
    irq_req = 1; tick(); irq_req = 0;
    chk(!stop_q && !bclk_div8, "R3 no settle divider kept", {stop_q, bclk_div8}, 2'b00);
    entry(1, 6'd63, 3'd1, 12'h8A5, 20'h0_0100, 0);
    sub_clk_sel = 0;

    // R6: software interrupts
    flg_in = 12'h0FF; pc_in = 20'h7_7777;
    swi_num = 6'd33; swi_req = 1; tick(); swi_req = 0;
    entry(0, 6'd33, 3'd0, 12'h0FF, 20'h7_7777, 0);
    swi_num = 6'd10; swi_req = 1; tick(); swi_req = 0;
    entry(0, 6'd10, 3'd0, 12'h0FF, 20'h7_7777, 0);

    // R10: hardware request with same-cycle stop write
    info_word = {5'h0, 3'd2, 2'b0, 6'd7};
    flg_in = 12'h3C3; pc_in = 20'h1_2000;
    irq_req = 1; stop_set = 1; tick(); irq_req = 0; stop_set = 0;
    chk(!stop_q, "R10 stop loses to request", stop_q, 0);
    entry(1, 6'd7, 3'd2, 12'h3C3, 20'h1_2000, 0);

    // R10: hardware request with same-cycle software interrupt
    info_word = {5'h0, 3'd4, 2'b0, 6'd12};
    swi_num = 6'd50;
    irq_req = 1; swi_req = 1; tick(); irq_req = 0; swi_req = 0;
    entry(1, 6'd12, 3'd4, 12'h3C3, 20'h1_2000, 0);

    // R11: stop and software pulses during a running entry
    info_word = {5'h0, 3'd5, 2'b0, 6'd2};
    irq_req = 1; tick(); irq_req = 0;
    entry(1, 6'd2, 3'd5, 12'h3C3, 20'h1_2000, 1);
    tick();
    quiet("R11 no late entry");
    chk(!stop_q, "R11 still running", stop_q, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule